// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit bidirectional buses, called A and B. Each bus is modelled with three signals: a data input that carries what outside devices drive, a data output, and an output enable. Every bus has a capture register. Each output port can forward either the live value of the opposite bus or the register captured from that opposite bus. The sixteen bits form two fully independent 8-bit lanes. Lane k covers bits 8k+7 down to 8k. Each lane has its own pair of capture clocks, its own pair of source selects and its own pair of output enables. A thin wrapper can turn each signal triple into a real tri-state pin.

The capture registers sample the resolved bus value. Where the block drives a bus itself, the resolved value is the block's own output; otherwise it is the external input. As a result, one direction can load the same data into both registers. A lane can also have both ports enabled with both selects set to live. In that case it acts as a bus keeper: an explicit per-lane hold register, clocked by `clk`, drives the last bus value onto both buses. Flag inputs model an outside device that overrides the kept value. There is no reset, and register contents are unknown until the first capture edge.

Top module: `regbus_xcvr`

## Requirements
- R1: A rising edge of a lane's `cp_ab` bit loads that lane's A capture register from the resolved A bus value, whatever the enables and selects are.
- R2: A rising edge of a lane's `cp_ba` bit loads that lane's B capture register from the resolved B bus value, whatever the enables and selects are.
- R3: With `en_ab` low and `en_ba_n` high, a lane drives neither bus: its `a_oe` and `b_oe` bits are 0.
- R4: `en_ab` high (active high) sets the lane's `b_oe` bit. With `sel_ab`=0 and the A port not driven, `b_out` follows `a_in` combinationally.
- R5: With `en_ab` high and `sel_ab`=1, `b_out` shows the lane's A capture register.
- R6: `en_ba_n` low (active low) sets the lane's `a_oe` bit. With `sel_ba`=1, `a_out` shows the B capture register. With `sel_ba`=0 and the B port not driven, `a_out` follows `b_in`.
- R7: With A-to-B enabled and live and the A port not driven, one simultaneous rise of both clocks loads `a_in` into both registers. In the mirror case (B-to-A enabled and live, B port not driven), `b_in` is loaded into both registers.
- R8: With both ports enabled and both selects at 1, `a_out` shows the B register and `b_out` shows the A register at the same time, and live inputs have no effect.
- R9: With both ports enabled and both selects at 0 (keeper), both outputs carry the A bus value that was present at the last `clk` rising edge before the mode was entered. This value holds while no override is active, and bus inputs are ignored.
- R10: In keeper mode, `a_ext` high puts `a_in` on both outputs at once. Otherwise `b_ext` high puts `b_in` on both outputs. The overriding value is kept after the flag drops, once a `clk` rising edge has occurred.
- R11: Outside keeper mode, `a_ext` and `b_ext` have no effect on any output.
- R12: The lanes are independent: a lane's controls and clocks never change the other lane's outputs or registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the keeper hold registers |
| cp_ab | input | 2 | Per-lane capture clock, A register |
| cp_ba | input | 2 | Per-lane capture clock, B register |
| en_ab | input | 2 | Per-lane B port drive enable, active high |
| en_ba_n | input | 2 | Per-lane A port drive enable, active low |
| sel_ab | input | 2 | Per-lane B source: 0 live A, 1 A register |
| sel_ba | input | 2 | Per-lane A source: 0 live B, 1 B register |
| a_ext | input | 2 | Per-lane outside device drives A bus (keeper override) |
| b_ext | input | 2 | Per-lane outside device drives B bus (keeper override) |
| a_in | input | 16 | A bus value driven from outside |
| a_out | output | 16 | A bus value driven by the block |
| a_oe | output | 2 | Per-lane A port drive |
| b_in | input | 16 | B bus value driven from outside |
| b_out | output | 16 | B bus value driven by the block |
| b_oe | output | 2 | Per-lane B port drive |

## Verification
The lane assertions check the routing relations on every evaluation, once the values are known. A stored select must show the opposite capture register. A live select with a single enabled port must forward the opposite input. A keeper lane must drive the same value on both buses. Only the bench scenarios can show which data a capture edge actually loaded and the value the keeper holds across clock edges. They also cover the override priority, and they show that lane 1 activity leaves lane 0 unchanged while both lanes run different modes at once.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic [2:0] {
    LM_ISOLATE    = 3'd0,
    LM_DRIVE_A    = 3'd1,
    LM_DRIVE_B    = 3'd2,
    LM_DRIVE_BOTH = 3'd3,
    LM_KEEPER     = 3'd4
  } lane_mode_e;

  // drv_a: block drives the A port; drv_b: block drives the B port.
  // stored_ab / stored_ba: 1 selects the capture register as source.
  function automatic lane_mode_e decode_mode(input logic drv_a, input logic drv_b,
                                             input logic stored_ab, input logic stored_ba);
    lane_mode_e m;
    if (drv_a && drv_b)
      m = (!stored_ab && !stored_ba) ? LM_KEEPER : LM_DRIVE_BOTH;
    else if (drv_a)
      m = LM_DRIVE_A;
    else if (drv_b)
      m = LM_DRIVE_B;
    else
      m = LM_ISOLATE;
    return m;
  endfunction

endpackage

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              cp_ab,
  input  logic              cp_ba,
  input  logic [LANE_W-1:0] a_bus,
  input  logic [LANE_W-1:0] b_bus,
  output logic [LANE_W-1:0] a_reg,
  output logic [LANE_W-1:0] b_reg,
  output logic [LANE_W-1:0] hold_q
);

  always_ff @(posedge cp_ab) a_reg <= a_bus;

  always_ff @(posedge cp_ba) b_reg <= b_bus;

  // Keeper: tracks the resolved A bus, which in keeper mode is itself
  // (or an override), so the value persists while the mode lasts.
  always_ff @(posedge clk) hold_q <= a_bus;

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
  import regbus_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic              drv_a,
  input  logic              drv_b,
  input  logic              stored_ab,
  input  logic              stored_ba,
  input  logic              a_ext,
  input  logic              b_ext,
  input  logic [LANE_W-1:0] a_in,
  input  logic [LANE_W-1:0] b_in,
  input  logic [LANE_W-1:0] a_reg,
  input  logic [LANE_W-1:0] b_reg,
  input  logic [LANE_W-1:0] hold_q,
  output logic [LANE_W-1:0] a_bus,
  output logic [LANE_W-1:0] b_bus,
  output logic              keeper
);

  lane_mode_e mode;
  logic [LANE_W-1:0] kept;

  assign mode   = decode_mode(drv_a, drv_b, stored_ab, stored_ba);
  assign keeper = (mode == LM_KEEPER);
  assign kept   = a_ext ? a_in : (b_ext ? b_in : hold_q);

  always_comb begin
    a_bus = a_in;
    b_bus = b_in;
    unique case (mode)
      LM_ISOLATE: begin
        a_bus = a_in;
        b_bus = b_in;
      end
      LM_DRIVE_A: begin
        b_bus = b_in;
        a_bus = stored_ba ? b_reg : b_in;
      end
      LM_DRIVE_B: begin
        a_bus = a_in;
        b_bus = stored_ab ? a_reg : a_in;
      end
      LM_DRIVE_BOTH: begin
        a_bus = stored_ba ? b_reg : a_reg;
        b_bus = stored_ab ? a_reg : b_reg;
      end
      LM_KEEPER: begin
        a_bus = kept;
        b_bus = kept;
      end
      default: begin
        a_bus = a_in;
        b_bus = b_in;
      end
    endcase
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              cp_ab,
  input  logic              cp_ba,
  input  logic              en_ab,
  input  logic              en_ba_n,
  input  logic              sel_ab,
  input  logic              sel_ba,
  input  logic              a_ext,
  input  logic              b_ext,
  input  logic [LANE_W-1:0] a_in,
  input  logic [LANE_W-1:0] b_in,
  output logic [LANE_W-1:0] a_out,
  output logic              a_oe,
  output logic [LANE_W-1:0] b_out,
  output logic              b_oe
);

  logic [LANE_W-1:0] a_reg, b_reg, hold_q, a_bus, b_bus;
  logic              keeper;

  assign a_oe = ~en_ba_n;
  assign b_oe = en_ab;

  xcvr_route #(.LANE_W(LANE_W)) route_i (
    .drv_a(a_oe), .drv_b(b_oe), .stored_ab(sel_ab), .stored_ba(sel_ba),
    .a_ext(a_ext), .b_ext(b_ext), .a_in(a_in), .b_in(b_in),
    .a_reg(a_reg), .b_reg(b_reg), .hold_q(hold_q),
    .a_bus(a_bus), .b_bus(b_bus), .keeper(keeper)
  );

  xcvr_capture #(.LANE_W(LANE_W)) capture_i (
    .clk(clk), .cp_ab(cp_ab), .cp_ba(cp_ba), .a_bus(a_bus), .b_bus(b_bus),
    .a_reg(a_reg), .b_reg(b_reg), .hold_q(hold_q)
  );

  assign a_out = a_bus;
  assign b_out = b_bus;

  always_comb begin
    if (!$isunknown({b_oe, sel_ab, b_out, a_reg}) && b_oe && sel_ab)
      AST_STORED_TO_B: assert (b_out == a_reg) else $error("stored A not on B"); // R5
    if (!$isunknown({a_oe, sel_ba, a_out, b_reg}) && a_oe && sel_ba)
      AST_STORED_TO_A: assert (a_out == b_reg) else $error("stored B not on A"); // R6
    if (!$isunknown({a_oe, b_oe, sel_ab, b_out, a_in}) && b_oe && !a_oe && !sel_ab)
      AST_LIVE_TO_B: assert (b_out == a_in) else $error("live A not on B"); // R4
    if (!$isunknown({a_oe, b_oe, sel_ba, a_out, b_in}) && a_oe && !b_oe && !sel_ba)
      AST_LIVE_TO_A: assert (a_out == b_in) else $error("live B not on A"); // R6
    if (!$isunknown({a_oe, b_oe, sel_ab, sel_ba, a_out, b_out}) && a_oe && b_oe && !sel_ab && !sel_ba)
      AST_KEEPER_AGREE: assert (keeper && a_out == b_out) else $error("keeper buses differ"); // R9
  end

endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic [LANES-1:0] cp_ab,
  input  logic [LANES-1:0] cp_ba,
  input  logic [LANES-1:0] en_ab,
  input  logic [LANES-1:0] en_ba_n,
  input  logic [LANES-1:0] sel_ab,
  input  logic [LANES-1:0] sel_ba,
  input  logic [LANES-1:0] a_ext,
  input  logic [LANES-1:0] b_ext,
  input  logic [W-1:0]     a_in,
  output logic [W-1:0]     a_out,
  output logic [LANES-1:0] a_oe,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     b_out,
  output logic [LANES-1:0] b_oe
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xcvr_lane #(.LANE_W(LANE_W)) lane_i (
      .clk    (clk),
      .cp_ab  (cp_ab[l]),
      .cp_ba  (cp_ba[l]),
      .en_ab  (en_ab[l]),
      .en_ba_n(en_ba_n[l]),
      .sel_ab (sel_ab[l]),
      .sel_ba (sel_ba[l]),
      .a_ext  (a_ext[l]),
      .b_ext  (b_ext[l]),
      .a_in   (a_in[l*LANE_W +: LANE_W]),
      .b_in   (b_in[l*LANE_W +: LANE_W]),
      .a_out  (a_out[l*LANE_W +: LANE_W]),
      .a_oe   (a_oe[l]),
      .b_out  (b_out[l*LANE_W +: LANE_W]),
      .b_oe   (b_oe[l])
    );
  end

endmodule

// File: tb/regbus_xcvr_tb.sv
`timescale 1ns/1ps
module regbus_xcvr_tb_top;

  logic        clk = 1'b0;
  logic [1:0]  cp_ab = '0, cp_ba = '0, en_ab = '0, en_ba_n = '1;
  logic [1:0]  sel_ab = '0, sel_ba = '0, a_ext = '0, b_ext = '0;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_oe, b_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  regbus_xcvr dut_i (
    .clk(clk), .cp_ab(cp_ab), .cp_ba(cp_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_ext(a_ext), .b_ext(b_ext),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk8(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
    chk(act === exp, req, what, {8'h0, act}, {8'h0, exp});
  endtask

  task automatic set_lane(input int l, input logic eab, input logic eban,
                          input logic sab, input logic sba);
    en_ab[l] = eab; en_ba_n[l] = eban; sel_ab[l] = sab; sel_ba[l] = sba;
  endtask

  task automatic pulse(input logic [1:0] m_ab, input logic [1:0] m_ba);
    #2; cp_ab = m_ab; cp_ba = m_ba;
    #2; cp_ab = '0; cp_ba = '0;
    #2;
  endtask

  task automatic t_isolation;
    set_lane(0, 0, 1, 1, 1); set_lane(1, 0, 1, 0, 0);
    a_in = 16'h1234; b_in = 16'h5678; #2;
    chk(a_oe === 2'b00, "R3", "a_oe in isolation", {14'h0, a_oe}, 16'h0);
    chk(b_oe === 2'b00, "R3", "b_oe in isolation", {14'h0, b_oe}, 16'h0);
  endtask

  task automatic t_a_to_b;
    set_lane(0, 0, 1, 0, 0);
    a_in[7:0] = 8'h5A;
    pulse(2'b01, 2'b00);                       // R1: capture with enables off
    a_in[7:0] = 8'h11; set_lane(0, 1, 1, 1, 0); #2;
    chk(b_oe[0] === 1'b1, "R4", "b_oe lane0", {15'h0, b_oe[0]}, 16'h1);
    chk8("R5", "stored A on B (R1 capture)", b_out[7:0], 8'h5A);
    sel_ab[0] = 0; #2;
    chk8("R4", "live A on B", b_out[7:0], 8'h11);
    a_in[7:0] = 8'h77; #2;
    chk8("R4", "live A follows", b_out[7:0], 8'h77);
    sel_ab[0] = 1; pulse(2'b01, 2'b00);        // R1: capture while enabled/stored
    a_in[7:0] = 8'h00; #2;
    chk8("R1", "capture under stored select", b_out[7:0], 8'h77);
  endtask

  task automatic t_b_to_a;
    set_lane(0, 0, 1, 0, 0);
    b_in[7:0] = 8'hC3;
    pulse(2'b00, 2'b01);
    b_in[7:0] = 8'h0F; set_lane(0, 0, 0, 0, 1); #2;
    chk(a_oe[0] === 1'b1, "R6", "a_oe lane0", {15'h0, a_oe[0]}, 16'h1);
    chk8("R2", "stored B on A", a_out[7:0], 8'hC3);
    sel_ba[0] = 0; #2;
    chk8("R6", "live B on A", a_out[7:0], 8'h0F);
  endtask

  task automatic t_both_regs;
    set_lane(1, 1, 1, 0, 0);
    a_in[15:8] = 8'hA5; b_in[15:8] = 8'h00;
    pulse(2'b10, 2'b10);
    a_in[15:8] = 8'h00;
    set_lane(1, 0, 0, 0, 1); #2;
    chk8("R7", "A data in B register", a_out[15:8], 8'hA5);
    set_lane(1, 1, 1, 1, 0); #2;
    chk8("R7", "A data in A register", b_out[15:8], 8'hA5);
    set_lane(1, 0, 0, 0, 0);
    b_in[15:8] = 8'h3C; a_in[15:8] = 8'hFF;
    pulse(2'b10, 2'b10);
    b_in[15:8] = 8'h00;
    set_lane(1, 1, 1, 1, 0); #2;
    chk8("R7", "B data in A register", b_out[15:8], 8'h3C);
    set_lane(1, 0, 0, 0, 1); #2;
    chk8("R7", "B data in B register", a_out[15:8], 8'h3C);
  endtask

  task automatic t_stored_both;
    set_lane(0, 0, 1, 0, 0);
    a_in[7:0] = 8'h21; b_in[7:0] = 8'h84;
    pulse(2'b01, 2'b01);
    set_lane(0, 1, 0, 1, 1);
    a_in[7:0] = 8'hEE; b_in[7:0] = 8'hDD; #2;
    chk8("R8", "B register on A", a_out[7:0], 8'h84);
    chk8("R8", "A register on B", b_out[7:0], 8'h21);
    chk(a_oe[0] === 1'b1 && b_oe[0] === 1'b1, "R8", "both enables",
        {14'h0, a_oe[0], b_oe[0]}, 16'h3);
  endtask

  task automatic t_keeper;
    set_lane(0, 1, 1, 0, 0); a_in[7:0] = 8'h3C;
    @(negedge clk); @(negedge clk);
    set_lane(0, 1, 0, 0, 0);
    a_in[7:0] = 8'hFF; b_in[7:0] = 8'h00; #2;
    chk8("R9", "keeper A", a_out[7:0], 8'h3C);
    chk8("R9", "keeper B", b_out[7:0], 8'h3C);
    repeat (3) @(negedge clk);
    chk8("R9", "keeper holds", b_out[7:0], 8'h3C);
    a_ext[0] = 1; a_in[7:0] = 8'h96; #2;
    chk8("R10", "A override on B", b_out[7:0], 8'h96);
    @(negedge clk); a_ext[0] = 0; a_in[7:0] = 8'h00; #2;
    chk8("R10", "A override kept", a_out[7:0], 8'h96);
    b_ext[0] = 1; b_in[7:0] = 8'h4B; #2;
    chk8("R10", "B override on A", a_out[7:0], 8'h4B);
    a_ext[0] = 1; a_in[7:0] = 8'hE1; #2;
    chk8("R10", "A override wins", b_out[7:0], 8'hE1);
    @(negedge clk); a_ext[0] = 0; b_ext[0] = 0; a_in[7:0] = 8'h12; b_in[7:0] = 8'h55; #2;
    chk8("R10", "override kept after release", b_out[7:0], 8'hE1);
    set_lane(0, 1, 1, 0, 0); b_ext[0] = 1; #2;
    chk8("R11", "b_ext ignored, live A", b_out[7:0], 8'h12);
    b_ext[0] = 0; set_lane(0, 0, 0, 0, 0); a_ext[0] = 1; #2;
    chk8("R11", "a_ext ignored, live B", a_out[7:0], 8'h55);
    a_ext[0] = 0;
  endtask

  task automatic t_lanes;
    set_lane(0, 0, 1, 0, 0); a_in[7:0] = 8'h42;
    pulse(2'b01, 2'b00);
    set_lane(0, 1, 1, 1, 0);
    set_lane(1, 0, 0, 0, 0);
    a_in = 16'hEEEE; b_in[15:8] = 8'h99;
    pulse(2'b10, 2'b10);
    chk(b_oe === 2'b01, "R12", "b_oe per lane", {14'h0, b_oe}, 16'h1);
    chk(a_oe === 2'b10, "R12", "a_oe per lane", {14'h0, a_oe}, 16'h2);
    chk8("R12", "lane0 register untouched", b_out[7:0], 8'h42);
    chk8("R12", "lane1 live B on A", a_out[15:8], 8'h99);
  endtask

  initial begin
    #1;
    t_isolation();
    t_a_to_b();
    t_b_to_a();
    t_both_regs();
    t_stored_both();
    t_keeper();
    t_lanes();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule